// File: doc/BRIEF.md
# Double-Width Rate Match Elastic Buffer

This block sits in a serial receive path that delivers two 9-bit symbols per word. Each symbol is a control flag in bit 8 and a byte in bits 7:0. Words enter on the recovered clock and leave on the local clock. The block absorbs the frequency difference between the two clocks by editing skip clusters. A skip cluster opens with a word that carries a comma symbol. When the buffer is too full, the skip pair that follows the comma word is dropped on entry. When the buffer is too shallow, an extra skip pair is emitted on exit after the comma word.

Hard limits are also covered. A word arriving at a full buffer is discarded. A read with nothing stored emits a padding pair. Full, empty and inserted flags travel with the output word they describe, so the core can line them up with the data.

Write and read pointers cross the clock boundary in Gray code through two-flop synchronizers. After reset, the read side emits padding pairs until half the buffer is filled. It then streams stored words in order.

Top module: `rmf_elastic_dw`

## Requirements
- R1: A reset in both domains leaves the output word at the padding pair, with the inserted, full and empty flags low.
- R2: After reset, every read cycle outputs the padding pair with the empty flag high until the read side sees at least DEPTH/2 stored words. A write that raises the count to DEPTH/2 produces its first stored word on the third read clock edge after it.
- R3: Stored words leave in arrival order and unmodified. The word layout is upper symbol in bits 17:9 and lower symbol in bits 8:0.
- R4: A word that arrives when the write side sees DEPTH-1 stored words is discarded and never appears at the output.
- R5: The first word accepted after one or more discarded words is output with the full flag high, for that word only.
- R6: Once streaming, a read cycle with no stored word outputs the padding pair {9'h1FE, 9'h1FE} with the empty flag high.
- R7: A skip pair {9'h11C, 9'h11C} that arrives directly after a word with a comma 9'h1BC in either half is discarded when the write-side count exceeds HI_MARK. Otherwise it is kept, and later skip pairs of the same cluster are always kept.
- R8: After a comma-carrying word is output, if the read-side count is below LO_MARK, one extra skip pair is output with the inserted flag high and the read pointer held. At most one pair is added per cluster.
- R9: The control flag is bit 8 of each symbol. Data symbols with the flag low pass through R7 and R8 untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_word | input | 18 | Incoming symbol pair, one per write clock |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_word | output | 18 | Outgoing symbol pair |
| rd_inserted | output | 1 | High on an output word that is an added skip pair |
| rd_full | output | 1 | High on the first word accepted after a discard |
| rd_empty | output | 1 | High on an output padding pair |

## Verification
A wrong pointer or a lost synchronizer stage shifts the output stream. The first stored word then leaves on the wrong read edge, or a word repeats or disappears. The scenarios compare every output word exactly, from the first padding pair onward, so such a fault shows within a few read cycles. A stale drop marker or a wrong threshold moves a flag onto a neighbouring word. It can also add or remove one skip pair, and the bench sees this on the very cluster that crosses the threshold.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

    typedef struct packed {
        logic       ctl;
        logic [7:0] val;
    } sym_t;

    typedef struct packed {
        sym_t hi;
        sym_t lo;
    } pair_t;

    typedef struct packed {
        logic  after_drop;
        pair_t data;
    } entry_t;

    localparam sym_t  SYM_SKIP  = sym_t'(9'h11C);
    localparam sym_t  SYM_COMMA = sym_t'(9'h1BC);
    localparam sym_t  SYM_PAD   = sym_t'(9'h1FE);
    localparam pair_t PAIR_SKIP = '{hi: SYM_SKIP, lo: SYM_SKIP};
    localparam pair_t PAIR_PAD  = '{hi: SYM_PAD,  lo: SYM_PAD};

    function automatic logic has_comma(pair_t p);
        return (p.hi == SYM_COMMA) || (p.lo == SYM_COMMA);
    endfunction

    function automatic logic is_skip_pair(pair_t p);
        return p == PAIR_SKIP;
    endfunction

endpackage

// File: rtl/rmf_ptr_rx.sv
module rmf_ptr_rx #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= gray_in;
            s2 <= s1;
        end
    end

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            bin_out[i] = ^(s2 >> i);
        end
    end
endmodule

// File: rtl/rmf_wr_ctl.sv
module rmf_wr_ctl
    import rmf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 9,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  pair_t         word_in,
    input  logic [PW-1:0] rd_bin,
    output logic          we,
    output logic [AW-1:0] waddr,
    output entry_t        wentry,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] level
);
    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH - 1);
    localparam logic [PW-1:0] HI_LVL   = PW'(HI_MARK);

    logic [PW-1:0] wbin, wbin_nx;
    logic          prev_comma, drop_pend, overflow, skip_del;

    always_comb begin
        level    = wbin - rd_bin;
        overflow = level >= FULL_LVL;
        skip_del = prev_comma && is_skip_pair(word_in) && (level > HI_LVL);
        we       = !overflow && !skip_del;
        wbin_nx  = wbin + 1'b1;
        waddr    = wbin[AW-1:0];
        wentry   = '{after_drop: drop_pend, data: word_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin       <= '0;
            wgray      <= '0;
            prev_comma <= 1'b0;
            drop_pend  <= 1'b0;
        end else begin
            prev_comma <= has_comma(word_in);
            if (we) begin
                wbin      <= wbin_nx;
                wgray     <= wbin_nx ^ (wbin_nx >> 1);
                drop_pend <= 1'b0;
            end else if (overflow) begin
                drop_pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rmf_rd_ctl.sv
module rmf_rd_ctl
    import rmf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LO_MARK = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] wr_bin,
    input  entry_t        head,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [PW-1:0] level,
    output pair_t         word_out,
    output logic          ins,
    output logic          full,
    output logic          empty
);
    localparam logic [PW-1:0] PRIME_LVL = PW'(DEPTH / 2);
    localparam logic [PW-1:0] LO_LVL    = PW'(LO_MARK);

    logic [PW-1:0] rbin, rbin_nx;
    logic          primed, primed_nx, do_ins, do_read;

    always_comb begin
        level     = wr_bin - rbin;
        primed_nx = primed || (level >= PRIME_LVL);
        do_ins    = primed && has_comma(word_out) && (level < LO_LVL);
        do_read   = primed_nx && !do_ins && (level != '0);
        rbin_nx   = rbin + 1'b1;
        raddr     = rbin[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin     <= '0;
            rgray    <= '0;
            primed   <= 1'b0;
            word_out <= PAIR_PAD;
            ins      <= 1'b0;
            full     <= 1'b0;
            empty    <= 1'b0;
        end else begin
            primed <= primed_nx;
            ins    <= do_ins;
            full   <= do_read && head.after_drop;
            empty  <= !do_ins && !do_read;
            if (do_ins)       word_out <= PAIR_SKIP;
            else if (do_read) word_out <= head.data;
            else              word_out <= PAIR_PAD;
            if (do_read) begin
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
            end
        end
    end
endmodule

// File: rtl/rmf_elastic_dw.sv
module rmf_elastic_dw
    import rmf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 9,
    parameter int LO_MARK = 4
) (
    input  logic        wr_clk,
    input  logic        wr_rst,
    input  logic [17:0] wr_word,
    input  logic        rd_clk,
    input  logic        rd_rst,
    output logic [17:0] rd_word,
    output logic        rd_inserted,
    output logic        rd_full,
    output logic        rd_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    entry_t        store [DEPTH];
    logic          we;
    logic [AW-1:0] waddr, raddr;
    entry_t        wentry, head;
    logic [PW-1:0] wgray, rgray, wr_bin_s, rd_bin_s, wr_level, rd_level;
    pair_t         out_pair;

    rmf_wr_ctl #(.DEPTH(DEPTH), .HI_MARK(HI_MARK)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .word_in(pair_t'(wr_word)), .rd_bin(rd_bin_s),
        .we(we), .waddr(waddr), .wentry(wentry), .wgray(wgray), .level(wr_level)
    );

    rmf_ptr_rx #(.PW(PW)) u_rptr_to_w (
        .clk(wr_clk), .rst(wr_rst), .gray_in(rgray), .bin_out(rd_bin_s)
    );

    rmf_ptr_rx #(.PW(PW)) u_wptr_to_r (
        .clk(rd_clk), .rst(rd_rst), .gray_in(wgray), .bin_out(wr_bin_s)
    );

    always_ff @(posedge wr_clk) begin
        if (we) store[waddr] <= wentry;
    end

    assign head = store[raddr];

    rmf_rd_ctl #(.DEPTH(DEPTH), .LO_MARK(LO_MARK)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .wr_bin(wr_bin_s), .head(head),
        .raddr(raddr), .rgray(rgray), .level(rd_level), .word_out(out_pair),
        .ins(rd_inserted), .full(rd_full), .empty(rd_empty)
    );

    assign rd_word = out_pair;
endmodule

// File: rtl/rmf_checker.sv
module rmf_checker
    import rmf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic [17:0]   rd_word,
    input logic          rd_inserted,
    input logic          rd_full,
    input logic          rd_empty,
    input logic [PW-1:0] wr_level,
    input logic [PW-1:0] rd_level
);
    localparam logic [PW-1:0] MAX_LVL = PW'(DEPTH - 1);

    p_no_overflow_r4: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_level <= MAX_LVL);

    p_rd_level_bound_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_level <= MAX_LVL);

    p_empty_is_pad_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_empty |-> (rd_word == 18'(PAIR_PAD)));

    p_ins_after_comma_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_inserted |-> ((rd_word == 18'(PAIR_SKIP)) && has_comma(pair_t'($past(rd_word)))));

    p_ins_single_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_inserted |=> !rd_inserted);

    p_full_on_data_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_full |-> (!rd_empty && !rd_inserted));
endmodule

bind rmf_elastic_dw rmf_checker #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .rd_word(rd_word), .rd_inserted(rd_inserted), .rd_full(rd_full),
    .rd_empty(rd_empty), .wr_level(wr_level), .rd_level(rd_level)
);

// File: tb/tb_rmf_elastic_dw.sv
module tb_rmf_elastic_dw;
    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst = 1'b1, rd_rst = 1'b1;
    logic [17:0] wr_word = '0;
    logic [17:0] rd_word;
    logic        rd_inserted, rd_full, rd_empty;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    localparam logic [17:0] PAD   = {9'h1FE, 9'h1FE};
    localparam logic [17:0] SKIP  = {9'h11C, 9'h11C};
    localparam logic [17:0] COMMA = {9'h11C, 9'h1BC};

    rmf_elastic_dw dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_word(wr_word),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_word(rd_word),
        .rd_inserted(rd_inserted), .rd_full(rd_full), .rd_empty(rd_empty)
    );

    function automatic logic [17:0] dw(int n);
        return {1'b0, 8'(2 * n), 1'b0, 8'(2 * n - 1)};
    endfunction

    // one write-clock cycle (write clock gated by the bench)
    task automatic wtick(input logic [17:0] w);
        wr_word = w;
        #5 wr_clk = 1'b1;
        #5 wr_clk = 1'b0;
    endtask

    // one 125 MHz read-clock cycle, outputs sampled after the falling edge
    task automatic rtick();
        #4 rd_clk = 1'b1;
        #4 rd_clk = 1'b0;
    endtask

    // flags are {inserted, full, empty}
    task automatic chk(input string req, input logic [17:0] exp_w, input logic [2:0] exp_f);
        n_chk++;
        if (rd_word !== exp_w || {rd_inserted, rd_full, rd_empty} !== exp_f) begin
            n_fail++;
            $display("FAIL %s: word=%h flags=%b expected word=%h flags=%b",
                     req, rd_word, {rd_inserted, rd_full, rd_empty}, exp_w, exp_f);
        end
    endtask

    task automatic rd_chk(input string req, input logic [17:0] exp_w, input logic [2:0] exp_f);
        rtick();
        chk(req, exp_w, exp_f);
    endtask

    task automatic do_reset();
        wr_rst = 1'b1; rd_rst = 1'b1;
        wtick('0); wtick('0);
        rtick(); rtick();
        wr_rst = 1'b0; rd_rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset state", PAD, 3'b000);
    endtask

    task automatic t_priming();
        do_reset();
        for (int i = 1; i <= 7; i++) wtick(dw(i));
        for (int i = 0; i < 3; i++) rd_chk("R2 pad while priming", PAD, 3'b001);
        wtick(dw(8));
        rd_chk("R2 sync stage 1", PAD, 3'b001);
        rd_chk("R2 sync stage 2", PAD, 3'b001);
        rd_chk("R2 first word on third edge", dw(1), 3'b000);
        for (int i = 2; i <= 8; i++) rd_chk("R3 in-order data R9", dw(i), 3'b000);
        rd_chk("R6 underflow pad", PAD, 3'b001);
        rd_chk("R6 underflow pad again", PAD, 3'b001);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 1; i <= 16; i++) wtick(dw(i));
        rd_chk("R2 pad before sync", PAD, 3'b001);
        rd_chk("R2 pad before sync", PAD, 3'b001);
        rd_chk("R3 first word", dw(1), 3'b000);
        wtick(dw(17)); wtick(dw(18)); wtick(dw(19));
        for (int i = 2; i <= 15; i++) rd_chk("R4 stored words kept", dw(i), 3'b000);
        rd_chk("R5 full on word after drops", dw(19), 3'b010);
        rd_chk("R4 dropped words absent", PAD, 3'b001);
    endtask

    task automatic t_delete();
        do_reset();
        for (int i = 1; i <= 9; i++) wtick(dw(i));
        wtick(COMMA); wtick(SKIP); wtick(SKIP);
        for (int i = 10; i <= 13; i++) wtick(dw(i));
        rtick(); rtick();
        for (int i = 1; i <= 9; i++) rd_chk("R3 data before cluster", dw(i), 3'b000);
        rd_chk("R7 comma word", COMMA, 3'b000);
        rd_chk("R7 one skip pair left", SKIP, 3'b000);
        for (int i = 10; i <= 13; i++) rd_chk("R7 data after cluster", dw(i), 3'b000);
        rd_chk("R6 pad at end", PAD, 3'b001);
    endtask

    task automatic t_insert();
        do_reset();
        for (int i = 1; i <= 7; i++) wtick(dw(i));
        wtick(COMMA); wtick(SKIP); wtick(dw(8));
        rtick(); rtick();
        for (int i = 1; i <= 7; i++) rd_chk("R3 data", dw(i), 3'b000);
        rd_chk("R8 comma word", COMMA, 3'b000);
        rd_chk("R8 inserted skip", SKIP, 3'b100);
        rd_chk("R8 original skip kept R7", SKIP, 3'b000);
        rd_chk("R8 data after cluster", dw(8), 3'b000);
        rd_chk("R6 pad at end", PAD, 3'b001);
    endtask

    initial begin
        t_reset();
        t_priming();
        t_overflow();
        t_delete();
        t_insert();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule